// File: doc/BRIEF.md
# Dithered 8+4 PWM Channel

This block is a single pulse-width-modulation channel that runs directly from the system clock. Software loads a 12-bit duty value through a byte-wide write port into two registers. The upper eight bits set a base high time. The lower four bits set a dither count. A free-running 12-bit cycle counter splits every 4096-clock frame into sixteen 256-clock sub-cycles. Each sub-cycle is high for the base count. Sub-cycles whose index is below the dither count stay high for one extra clock. The visible switching rate is therefore clock/256, while the average over a frame keeps the full 12-bit resolution of duty/4096.

The duty value written by software is moved into the working copy only at a frame boundary, or at any time while the channel is off. A frame therefore never mixes old and new settings. Two pin-level inputs sit after the generator. A port-data gate forces the output low without stopping the counter. A direction input marks the pin as an input; this drops both the output and its output-enable.

Top module: `dpwm_chan`

## Requirements
- R1: After reset the channel is off, and `pwm_o` and `pwm_oe_o` are 0.
- R2: With `wr_sel`=1, a write loads `wr_data[7:0]` as the base count, which is duty bits 11..4. With `wr_sel`=0, `wr_data[0]` is the enable and `wr_data[7:4]` is the dither count, which is duty bits 3..0. `wr_data[3:1]` of a low write has no effect on the waveform.
- R3: In sub-cycle i (0..15) of a running frame, the output is high from the first clock for base+1 clocks when i < dither, and for base clocks otherwise. It is low for the rest of the 256 clocks.
- R4: With base 255 and i < dither, sub-cycle i is high for all 256 clocks.
- R5: A frame lasts 4096 clocks, and the total number of high clocks in a frame equals the 12-bit duty value.
- R6: A duty write made during a frame does not change that frame. The new value governs the next frame, including a write made in the frame's last clock.
- R7: While disabled, the output is low and the cycle counter is held at 0. The clock after an enabling write is clock 0 of sub-cycle 0.
- R8: While `gate_i` is 0, `pwm_o` is 0 and the counter keeps running, so the waveform resumes in phase when the gate returns to 1.
- R9: While `dir_in_i` is 1, `pwm_o` and `pwm_oe_o` are 0. Otherwise `pwm_oe_o` equals the enable.
- R10: A duty value of 0 keeps the output low for the whole frame while enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = low register (enable, dither), 1 = high register (base) |
| wr_data | input | 8 | Write data |
| gate_i | input | 1 | Port-data gate; 0 forces the output low |
| dir_in_i | input | 1 | 1 = pin used as input, output released |
| pwm_o | output | 1 | Gated PWM output |
| pwm_oe_o | output | 1 | Output enable for the pin driver |

## Verification
Two things can happen in the same clock: the frame-boundary reload of the working duty copy, and a software write to the duty registers. The bench provokes this by counting to the last clock of a frame and writing the high register exactly there. It then judges the result by counting the high clocks of the following frame against the new duty value. Separately, a bench-side cycle model of the frame counter and reload rule is compared with the output on every clock. This covers random writes, gate toggles and direction changes that land at arbitrary counter phases.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  localparam int BASE_W = 8;
  localparam int DITH_W = 4;
  localparam int REG_W  = 8;
  typedef enum logic {SEL_LOW = 1'b0, SEL_HIGH = 1'b1} reg_sel_e;
endpackage

// File: rtl/dpwm_rst_sync.sv
module dpwm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dpwm_regfile.sv
module dpwm_regfile
  import dpwm_pkg::*;
#(
  parameter int BASE_W = dpwm_pkg::BASE_W,
  parameter int DITH_W = dpwm_pkg::DITH_W,
  parameter int REG_W  = dpwm_pkg::REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [REG_W-1:0]  wr_data,
  output logic [BASE_W-1:0] base_q,
  output logic [DITH_W-1:0] dith_q,
  output logic              en_q,
  output logic [BASE_W-1:0] base_d,
  output logic [DITH_W-1:0] dith_d,
  output logic              en_d
);
  always_comb begin
    base_d = base_q;
    dith_d = dith_q;
    en_d   = en_q;
    if (wr_en) begin
      if (reg_sel_e'(wr_sel) == SEL_HIGH) begin
        base_d = wr_data[BASE_W-1:0];
      end else begin
        en_d   = wr_data[0];
        dith_d = wr_data[REG_W-1 -: DITH_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      dith_q <= '0;
      en_q   <= 1'b0;
    end else if (wr_en) begin
      base_q <= base_d;
      dith_q <= dith_d;
      en_q   <= en_d;
    end
  end
endmodule

// File: rtl/dpwm_timebase.sv
module dpwm_timebase #(
  parameter int BASE_W = dpwm_pkg::BASE_W,
  parameter int DITH_W = dpwm_pkg::DITH_W,
  localparam int CYC_W = BASE_W + DITH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_q,
  input  logic              en_d,
  input  logic [BASE_W-1:0] base_d,
  input  logic [DITH_W-1:0] dith_d,
  output logic [CYC_W-1:0]  cnt_q,
  output logic [BASE_W-1:0] abase_q,
  output logic [DITH_W-1:0] adith_q
);
  localparam logic [CYC_W-1:0] CNT_LAST = '1;

  logic [CYC_W-1:0]  cnt_d;
  logic              load;
  logic [BASE_W-1:0] abase_d;
  logic [DITH_W-1:0] adith_d;

  always_comb begin
    cnt_d   = (en_d && en_q) ? cnt_q + CYC_W'(1) : '0;
    load    = !en_q || (cnt_q == CNT_LAST);
    abase_d = load ? base_d : abase_q;
    adith_d = load ? dith_d : adith_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      abase_q <= '0;
      adith_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (load) begin
        abase_q <= abase_d;
        adith_q <= adith_d;
      end
    end
  end
endmodule

// File: rtl/dpwm_slicer.sv
module dpwm_slicer #(
  parameter int BASE_W = dpwm_pkg::BASE_W,
  parameter int DITH_W = dpwm_pkg::DITH_W,
  localparam int CYC_W = BASE_W + DITH_W
) (
  input  logic              en_q,
  input  logic [CYC_W-1:0]  cnt_q,
  input  logic [BASE_W-1:0] abase_q,
  input  logic [DITH_W-1:0] adith_q,
  input  logic              gate_i,
  input  logic              dir_in_i,
  output logic              pwm_o,
  output logic              pwm_oe_o
);
  logic [DITH_W-1:0] sub_idx;
  logic [BASE_W-1:0] pos;
  logic              extra;
  logic [BASE_W:0]   thr;
  logic              raw;

  always_comb begin
    sub_idx  = cnt_q[CYC_W-1:BASE_W];
    pos      = cnt_q[BASE_W-1:0];
    extra    = (sub_idx < adith_q);
    thr      = {1'b0, abase_q} + {{BASE_W{1'b0}}, extra};
    raw      = en_q && ({1'b0, pos} < thr);
    pwm_o    = raw && gate_i && !dir_in_i;
    pwm_oe_o = en_q && !dir_in_i;
  end
endmodule

// File: rtl/dpwm_chan.sv
module dpwm_chan
  import dpwm_pkg::*;
#(
  parameter int BASE_W = dpwm_pkg::BASE_W,
  parameter int DITH_W = dpwm_pkg::DITH_W,
  parameter int REG_W  = dpwm_pkg::REG_W,
  localparam int CYC_W = BASE_W + DITH_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             gate_i,
  input  logic             dir_in_i,
  output logic             pwm_o,
  output logic             pwm_oe_o
);
  logic              rst_q;
  logic [BASE_W-1:0] base_q, base_d, abase_q;
  logic [DITH_W-1:0] dith_q, dith_d, adith_q;
  logic              en_q, en_d;
  logic [CYC_W-1:0]  cnt_q;

  dpwm_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q)
  );

  dpwm_regfile #(.BASE_W(BASE_W), .DITH_W(DITH_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_q), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .base_q(base_q), .dith_q(dith_q), .en_q(en_q),
    .base_d(base_d), .dith_d(dith_d), .en_d(en_d)
  );

  dpwm_timebase #(.BASE_W(BASE_W), .DITH_W(DITH_W)) u_tb (
    .clk(clk), .rst_n(rst_q), .en_q(en_q), .en_d(en_d),
    .base_d(base_d), .dith_d(dith_d),
    .cnt_q(cnt_q), .abase_q(abase_q), .adith_q(adith_q)
  );

  dpwm_slicer #(.BASE_W(BASE_W), .DITH_W(DITH_W)) u_slc (
    .en_q(en_q), .cnt_q(cnt_q), .abase_q(abase_q), .adith_q(adith_q),
    .gate_i(gate_i), .dir_in_i(dir_in_i), .pwm_o(pwm_o), .pwm_oe_o(pwm_oe_o)
  );
endmodule

// File: rtl/dpwm_chan_chk.sv
module dpwm_chan_chk #(
  parameter int BASE_W = dpwm_pkg::BASE_W,
  parameter int DITH_W = dpwm_pkg::DITH_W,
  localparam int CYC_W = BASE_W + DITH_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_q,
  input logic [CYC_W-1:0]  cnt_q,
  input logic [BASE_W-1:0] abase_q,
  input logic [DITH_W-1:0] adith_q,
  input logic              gate_i,
  input logic              dir_in_i,
  input logic              pwm_o,
  input logic              pwm_oe_o
);
  AST_IDLE_HELD: assert property (@(posedge clk) disable iff (!rst_n) !en_q |-> cnt_q == '0); // R7
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) (en_q && $past(en_q)) |-> cnt_q == ($past(cnt_q) + CYC_W'(1))); // R5
  AST_DUTY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (en_q && cnt_q != '0) |-> ($stable(abase_q) && $stable(adith_q))); // R6
  AST_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !gate_i |-> !pwm_o); // R8
  AST_DIR_QUIET: assert property (@(posedge clk) disable iff (!rst_n) dir_in_i |-> (!pwm_o && !pwm_oe_o)); // R9
  AST_SUB_START: assert property (@(posedge clk) disable iff (!rst_n) (en_q && cnt_q[BASE_W-1:0] == '0 && abase_q != '0 && gate_i && !dir_in_i) |-> pwm_o); // R3
  AST_FULL_SUB: assert property (@(posedge clk) disable iff (!rst_n) (en_q && (&abase_q) && cnt_q[CYC_W-1:BASE_W] < adith_q && gate_i && !dir_in_i) |-> pwm_o); // R4
endmodule

bind dpwm_chan dpwm_chan_chk #(.BASE_W(BASE_W), .DITH_W(DITH_W)) u_chk (
  .clk(clk), .rst_n(rst_q), .en_q(en_q), .cnt_q(cnt_q), .abase_q(abase_q),
  .adith_q(adith_q), .gate_i(gate_i), .dir_in_i(dir_in_i),
  .pwm_o(pwm_o), .pwm_oe_o(pwm_oe_o)
);

// File: tb/sim_dpwm_chan.sv
`timescale 1ns/1ps
module sim_dpwm_chan;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, wr_sel, gate_i, dir_in_i;
  logic [7:0] wr_data;
  logic       pwm_o, pwm_oe_o;

  int    n_cmp = 0, n_bad = 0;
  bit    done = 1'b0, cmp_on = 1'b0;
  string cur_tag = "R3";

  // reference model state
  logic        m_en;
  logic [7:0]  m_base, m_ab;
  logic [3:0]  m_dith, m_ad;
  logic [11:0] m_cnt;

  always #10 clk = ~clk;

  dpwm_chan u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .gate_i(gate_i), .dir_in_i(dir_in_i), .pwm_o(pwm_o), .pwm_oe_o(pwm_oe_o)
  );

  function automatic logic exp_raw(input logic en, input logic [11:0] cnt,
                                   input logic [7:0] b, input logic [3:0] d);
    int thr;
    thr = int'(b) + ((cnt[11:8] < d) ? 1 : 0);
    return en && (int'(cnt[7:0]) < thr);
  endfunction

  function automatic int sub_high(input logic [11:0] duty, input int i);
    return int'(duty[11:4]) + ((i < int'(duty[3:0])) ? 1 : 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    logic       ne;
    logic [7:0] nb;
    logic [3:0] nd;
    if (!rst_n) begin
      m_en <= 1'b0; m_base <= '0; m_dith <= '0; m_cnt <= '0; m_ab <= '0; m_ad <= '0;
    end else begin
      ne = m_en; nb = m_base; nd = m_dith;
      if (wr_en) begin
        if (wr_sel) nb = wr_data;
        else begin ne = wr_data[0]; nd = wr_data[7:4]; end
      end
      m_en <= ne; m_base <= nb; m_dith <= nd;
      m_cnt <= (ne && m_en) ? m_cnt + 12'd1 : 12'd0;
      if (!m_en || m_cnt == 12'hFFF) begin m_ab <= nb; m_ad <= nd; end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n && cmp_on) begin : cmp
      logic  e, eo;
      string t;
      e  = exp_raw(m_en, m_cnt, m_ab, m_ad) && gate_i && !dir_in_i;
      eo = m_en && !dir_in_i;
      t  = dir_in_i ? "R9" : (!gate_i ? "R8" : (!m_en ? "R7" : cur_tag));
      check(pwm_o === e, t, int'(pwm_o), int'(e));
      check(pwm_oe_o === eo, "R9", int'(pwm_oe_o), int'(eo));
    end
  end

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_highs(input int n, output int h);
    h = 0;
    repeat (n) begin
      #1;
      if (pwm_o) h++;
      @(negedge clk);
    end
  endtask

  task automatic measure(input logic [11:0] d, input string tag, input logic [2:0] junk);
    int h, tot;
    wr(1'b0, {4'h0, junk, 1'b0});
    wr(1'b1, d[11:4]);
    wr(1'b0, {d[3:0], junk, 1'b1});
    tot = 0;
    for (int i = 0; i < 16; i++) begin
      count_highs(256, h);
      tot += h;
      check(h == sub_high(d, i), (d[11:4] == 8'hFF && i < int'(d[3:0])) ? "R4" : "R3",
            h, sub_high(d, i));
    end
    check(tot == int'(d), tag, tot, int'(d));
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int h;
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0; gate_i = 1'b0; dir_in_i = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(pwm_o == 1'b0, "R1", int'(pwm_o), 0);
    check(pwm_oe_o == 1'b0, "R1", int'(pwm_oe_o), 0);
    cmp_on = 1'b1;
    gate_i = 1'b1;

    measure(12'h000, "R10", 3'b000);
    measure(12'h001, "R5", 3'b000);
    measure(12'hFFF, "R4", 3'b000);
    measure(12'hFF7, "R4", 3'b000);
    measure(12'h3A5, "R5", 3'b000);

    // R6: mid-frame write keeps the running frame
    cur_tag = "R6";
    repeat (40) @(negedge clk);
    wr(1'b1, 8'h10);
    count_highs(215, h);
    check(h == 18, "R6", h, 18);
    count_highs(4096 - 256, h);
    count_highs(4096, h);
    check(h == 12'h105, "R6", h, 12'h105);

    // R7: disable holds low, enable restarts at sub-cycle 0
    cur_tag = "R7";
    wr(1'b0, 8'h50);
    count_highs(100, h);
    check(h == 0, "R7", h, 0);
    wr(1'b0, 8'h51);
    #1;
    check(pwm_o == 1'b1, "R7", int'(pwm_o), 1);
    count_highs(256, h);
    check(h == 17, "R7", h, 17);

    // R2: ignored low-register bits
    cur_tag = "R2";
    measure(12'h7C9, "R2", 3'b111);

    // R8: gate low silences output, counter keeps phase
    gate_i = 1'b0;
    count_highs(4096, h);
    check(h == 0, "R8", h, 0);
    gate_i = 1'b1;
    count_highs(4096, h);
    check(h == 12'h7C9, "R8", h, 12'h7C9);

    // R9: input direction releases the pin
    dir_in_i = 1'b1;
    count_highs(300, h);
    check(h == 0, "R9", h, 0);
    #1;
    check(pwm_oe_o == 1'b0, "R9", int'(pwm_oe_o), 0);
    dir_in_i = 1'b0;
    #1;
    check(pwm_oe_o == 1'b1, "R9", int'(pwm_oe_o), 1);

    // R6: write in the last clock of a frame governs the next frame
    cur_tag = "R6";
    measure(12'h800, "R5", 3'b000);
    repeat (4095) @(negedge clk);
    wr(1'b1, 8'h20);
    count_highs(4096, h);
    check(h == 12'h200, "R6", h, 12'h200);

    // random duty frames
    cur_tag = "R3";
    for (int k = 0; k < 10; k++) begin
      logic [11:0] d;
      d = 12'($urandom);
      measure(d, "R5", 3'($urandom));
    end

    // random mix of writes, gate and direction
    for (int k = 0; k < 3000; k++) begin
      if ($urandom % 8 == 0) gate_i = ~gate_i;
      if ($urandom % 16 == 0) dir_in_i = ~dir_in_i;
      if ($urandom % 64 == 0) wr(1'($urandom), 8'($urandom | 32'h1));
      else @(negedge clk);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule